// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits directly behind the instruction memory in a small 32-bit processor. It takes the program counter and a six-byte window read starting at that address. From byte 0 it separates the operation code and the function code. The operation code alone decides how long the instruction is: 1, 2, 5 or 6 bytes. It also decides whether a register-specifier byte follows and whether a 32-bit constant follows. The block pulls out the two register fields and assembles the little-endian constant. It also produces the fall-through address.

Malformed first bytes are flagged as illegal and treated as one-byte instructions. All results are registered, so the stage can be retimed into a fetch pipeline. Because the length changes with the opcode, the next PC cannot be a fixed increment, and this block is the one that provides it.

Top module: `ifetch_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs take their reset values at that edge: every numeric field 0, `ra_o`/`rb_o` = 0xF, every flag 0.
- R2: One cycle after inputs are presented, `icode_o` equals the high nibble of byte 0 and `ifun_o` equals its low nibble (byte k is `bytes_i[8k+7:8k]`).
- R3: Opcode codes and forms are as follows. Codes 0x0, 0x1 and 0x9 are 1 byte, with no register byte and no constant. Codes 0x2, 0x6, 0xA and 0xB are 2 bytes, with a register byte. Codes 0x7 and 0x8 are 5 bytes, with a constant and no register byte. Codes 0x3, 0x4 and 0x5 are 6 bytes, with both a register byte and a constant. `len_o`, `has_reg_o` and `has_const_o` report these values.
- R4: When a register byte is present it is byte 1: `ra_o` is its high nibble and `rb_o` its low nibble. Both are passed unchanged, including 0xF.
- R5: When there is no register byte, `ra_o` and `rb_o` are 0xF.
- R6: The constant is taken from bytes 2..5 when a register byte is present, and from bytes 1..4 otherwise. The lowest-addressed byte is the least significant.
- R7: When there is no constant, `valc_o` is 0.
- R8: `valp_o` equals the presented PC plus `len_o`, modulo 2^32.
- R9: `bad_o` is 1 when the opcode is above 0xB, or when the function code is nonzero on any opcode other than 0x6 and 0x7. Such an instruction is reported as 1 byte long, with no register byte and no constant.
- R10: Any function code is legal on opcodes 0x6 and 0x7 and is passed through in `ifun_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of byte 0 |
| bytes_i | input | 48 | Instruction window, byte k at bits 8k+7:8k |
| icode_o | output | 4 | Operation code |
| ifun_o | output | 4 | Function code |
| ra_o | output | 4 | First register field |
| rb_o | output | 4 | Second register field |
| valc_o | output | 32 | Constant word |
| valp_o | output | 32 | Fall-through address |
| len_o | output | 3 | Instruction length in bytes |
| has_reg_o | output | 1 | Register byte present |
| has_const_o | output | 1 | Constant word present |
| bad_o | output | 1 | Illegal instruction |

## Verification
Every result is held in one output register, so each field is due at the first rising edge after its inputs are applied. The bench changes inputs on the falling edge. It waits for one rising edge and compares all fields at the next falling edge, so every sample lands mid-cycle, after exactly one register stage. A back-to-back pair of instructions and a reset applied with live inputs confirm that the latency is exactly one cycle and that reset overrides decoding.

// File: rtl/fd_pkg.sv
package fd_pkg;
  typedef enum logic [3:0] {
    OPC_NOP   = 4'h0,
    OPC_HALT  = 4'h1,
    OPC_MOVRR = 4'h2,
    OPC_MOVIR = 4'h3,
    OPC_MOVRM = 4'h4,
    OPC_MOVMR = 4'h5,
    OPC_ALU   = 4'h6,
    OPC_JUMP  = 4'h7,
    OPC_CALL  = 4'h8,
    OPC_RET   = 4'h9,
    OPC_PUSH  = 4'hA,
    OPC_POP   = 4'hB
  } opc_e;

  localparam logic [3:0] NO_REG = 4'hF;
endpackage

// File: rtl/fd_form.sv
module fd_form
  import fd_pkg::*;
(
  input  logic [3:0] icode,
  input  logic [3:0] ifun,
  output logic       has_reg,
  output logic       has_const,
  output logic       bad
);
  logic known;
  logic fun_ok;

  always_comb begin
    known     = 1'b1;
    has_reg   = 1'b0;
    has_const = 1'b0;
    case (icode)
      OPC_NOP, OPC_HALT, OPC_RET: ;
      OPC_MOVRR, OPC_ALU, OPC_PUSH, OPC_POP: has_reg = 1'b1;
      OPC_JUMP, OPC_CALL: has_const = 1'b1;
      OPC_MOVIR, OPC_MOVRM, OPC_MOVMR: begin
        has_reg   = 1'b1;
        has_const = 1'b1;
      end
      default: known = 1'b0;
    endcase
    fun_ok = (ifun == 4'h0) || (icode == OPC_ALU) || (icode == OPC_JUMP);
    bad    = !(known && fun_ok);
    if (bad) begin
      has_reg   = 1'b0;
      has_const = 1'b0;
    end
  end
endmodule

// File: rtl/fd_fields.sv
module fd_fields
  import fd_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int MAX_LEN = WORD_BYTES + 2
) (
  input  logic [MAX_LEN*8-1:0] bytes,
  input  logic                 has_reg,
  input  logic                 has_const,
  output logic [3:0]           ra,
  output logic [3:0]           rb,
  output logic [WORD_W-1:0]    valc
);
  logic [WORD_W-1:0] raw_after_reg;
  logic [WORD_W-1:0] raw_after_op;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_const
    assign raw_after_reg[8*k +: 8] = bytes[8*(k+2) +: 8];
    assign raw_after_op[8*k +: 8]  = bytes[8*(k+1) +: 8];
  end

  always_comb begin
    ra = has_reg ? bytes[15:12] : NO_REG;
    rb = has_reg ? bytes[11:8]  : NO_REG;
    if (!has_const)   valc = '0;
    else if (has_reg) valc = raw_after_reg;
    else              valc = raw_after_op;
  end
endmodule

// File: rtl/ifetch_decoder.sv
module ifetch_decoder
  import fd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int MAX_LEN = WORD_BYTES + 2,
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    pc_i,
  input  logic [MAX_LEN*8-1:0] bytes_i,
  output logic [3:0]           icode_o,
  output logic [3:0]           ifun_o,
  output logic [3:0]           ra_o,
  output logic [3:0]           rb_o,
  output logic [WORD_W-1:0]    valc_o,
  output logic [ADDR_W-1:0]    valp_o,
  output logic [LEN_W-1:0]     len_o,
  output logic                 has_reg_o,
  output logic                 has_const_o,
  output logic                 bad_o
);
  logic [3:0]        icode_c, ifun_c, ra_c, rb_c;
  logic              has_reg_c, has_const_c, bad_c;
  logic [WORD_W-1:0] valc_c;
  logic [LEN_W-1:0]  len_c;
  logic [ADDR_W-1:0] valp_c;

  assign icode_c = bytes_i[7:4];
  assign ifun_c  = bytes_i[3:0];

  fd_form u_form (
    .icode     (icode_c),
    .ifun      (ifun_c),
    .has_reg   (has_reg_c),
    .has_const (has_const_c),
    .bad       (bad_c)
  );

  fd_fields #(.WORD_W(WORD_W)) u_fields (
    .bytes     (bytes_i),
    .has_reg   (has_reg_c),
    .has_const (has_const_c),
    .ra        (ra_c),
    .rb        (rb_c),
    .valc      (valc_c)
  );

  always_comb begin
    len_c  = LEN_W'(1) + LEN_W'(has_reg_c)
           + (has_const_c ? LEN_W'(WORD_BYTES) : LEN_W'(0));
    valp_c = pc_i + ADDR_W'(len_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      icode_o     <= '0;
      ifun_o      <= '0;
      ra_o        <= NO_REG;
      rb_o        <= NO_REG;
      valc_o      <= '0;
      valp_o      <= '0;
      len_o       <= '0;
      has_reg_o   <= 1'b0;
      has_const_o <= 1'b0;
      bad_o       <= 1'b0;
    end else begin
      icode_o     <= icode_c;
      ifun_o      <= ifun_c;
      ra_o        <= ra_c;
      rb_o        <= rb_c;
      valc_o      <= valc_c;
      valp_o      <= valp_c;
      len_o       <= len_c;
      has_reg_o   <= has_reg_c;
      has_const_o <= has_const_c;
      bad_o       <= bad_c;
    end
  end
endmodule

// File: rtl/ifetch_decoder_chk.sv
module ifetch_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int MAX_LEN = 6,
  parameter int LEN_W = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    pc_i,
  input logic [MAX_LEN*8-1:0] bytes_i,
  input logic [3:0]           icode_o,
  input logic [3:0]           ifun_o,
  input logic [3:0]           ra_o,
  input logic [3:0]           rb_o,
  input logic [WORD_W-1:0]    valc_o,
  input logic [ADDR_W-1:0]    valp_o,
  input logic [LEN_W-1:0]     len_o,
  input logic                 has_reg_o,
  input logic                 has_const_o,
  input logic                 bad_o
);
  logic armed;
  logic [3:0] b0_hi, b0_lo, b1_hi, b1_lo;
  logic [7:0] b2;

  assign b0_hi = bytes_i[7:4];
  assign b0_lo = bytes_i[3:0];
  assign b1_hi = bytes_i[15:12];
  assign b1_lo = bytes_i[11:8];
  assign b2    = bytes_i[23:16];

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_OPCODE_SPLIT: assert property (@(posedge clk) disable iff (rst)
    armed |-> (icode_o == $past(b0_hi) && ifun_o == $past(b0_lo))); // R2

  AST_REG_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (armed && has_reg_o) |-> (ra_o == $past(b1_hi) && rb_o == $past(b1_lo))); // R4

  AST_NOREG_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (armed && !has_reg_o) |-> (ra_o == 4'hF && rb_o == 4'hF)); // R5

  AST_CONST_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
    (armed && has_reg_o && has_const_o) |-> (valc_o[7:0] == $past(b2))); // R6

  AST_NOCONST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && !has_const_o) |-> (valc_o == '0)); // R7

  AST_NEXT_PC: assert property (@(posedge clk) disable iff (rst)
    armed |-> (valp_o == $past(pc_i) + ADDR_W'(len_o))); // R8

  AST_BAD_SHORT: assert property (@(posedge clk) disable iff (rst)
    (armed && bad_o) |-> (len_o == LEN_W'(1) && !has_reg_o && !has_const_o)); // R9
endmodule

bind ifetch_decoder ifetch_decoder_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .pc_i(pc_i), .bytes_i(bytes_i),
  .icode_o(icode_o), .ifun_o(ifun_o), .ra_o(ra_o), .rb_o(rb_o),
  .valc_o(valc_o), .valp_o(valp_o), .len_o(len_o),
  .has_reg_o(has_reg_o), .has_const_o(has_const_o), .bad_o(bad_o)
);

// File: tb/ifetch_decoder_test.sv
module ifetch_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_i = '0;
  logic [47:0] bytes_i = '0;
  logic [3:0]  icode_o, ifun_o, ra_o, rb_o;
  logic [31:0] valc_o, valp_o;
  logic [2:0]  len_o;
  logic        has_reg_o, has_const_o, bad_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ifetch_decoder uut (.*);

  function automatic logic [47:0] mk(input logic [7:0] a0, a1, a2, a3, a4, a5);
    return {a5, a4, a3, a2, a1, a0};
  endfunction

  task automatic cmp(input string req, input string name, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, name, act, exp);
    end
  endtask

  task automatic expect_all(input string req, input logic [3:0] ic, fn, ra, rb,
                            input logic [31:0] vc, vp, input logic [2:0] ln,
                            input logic hr, hc, bd);
    cmp(req, "icode", 32'(icode_o), 32'(ic));
    cmp(req, "ifun",  32'(ifun_o),  32'(fn));
    cmp(req, "ra",    32'(ra_o),    32'(ra));
    cmp(req, "rb",    32'(rb_o),    32'(rb));
    cmp(req, "valc",  valc_o, vc);
    cmp(req, "valp",  valp_o, vp);
    cmp(req, "len",   32'(len_o),   32'(ln));
    cmp(req, "has_reg",   32'(has_reg_o),   32'(hr));
    cmp(req, "has_const", 32'(has_const_o), 32'(hc));
    cmp(req, "bad",   32'(bad_o),   32'(bd));
  endtask

  task automatic apply(input logic [31:0] pc, input logic [47:0] b);
    @(negedge clk);
    pc_i = pc;
    bytes_i = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    pc_i = 32'h1234;
    bytes_i = mk(8'h30, 8'h12, 8'h11, 8'h22, 8'h33, 8'h44);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    expect_all("R1", 4'h0, 4'h0, 4'hF, 4'hF, 0, 0, 3'd0, 0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic t_one_byte;
    apply(32'h100, mk(8'h00, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE));
    expect_all("R3 R5 R7 nop", 4'h0, 4'h0, 4'hF, 4'hF, 0, 32'h101, 3'd1, 0, 0, 0);
    apply(32'h200, mk(8'h10, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A));
    expect_all("R3 halt", 4'h1, 4'h0, 4'hF, 4'hF, 0, 32'h201, 3'd1, 0, 0, 0);
    apply(32'h300, mk(8'h90, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99));
    expect_all("R3 ret", 4'h9, 4'h0, 4'hF, 4'hF, 0, 32'h301, 3'd1, 0, 0, 0);
  endtask

  task automatic t_two_byte;
    apply(32'h400, mk(8'h20, 8'h13, 8'hFF, 8'hFF, 8'hFF, 8'hFF));
    expect_all("R3 R4 movrr", 4'h2, 4'h0, 4'h1, 4'h3, 0, 32'h402, 3'd2, 1, 0, 0);
    apply(32'h410, mk(8'h63, 8'h27, 8'h01, 8'h02, 8'h03, 8'h04));
    expect_all("R10 R4 alu", 4'h6, 4'h3, 4'h2, 4'h7, 0, 32'h412, 3'd2, 1, 0, 0);
    apply(32'h420, mk(8'hA0, 8'h4F, 8'h00, 8'h00, 8'h00, 8'h00));
    expect_all("R4 push", 4'hA, 4'h0, 4'h4, 4'hF, 0, 32'h422, 3'd2, 1, 0, 0);
    apply(32'h430, mk(8'hB0, 8'h6F, 8'h00, 8'h00, 8'h00, 8'h00));
    expect_all("R4 pop", 4'hB, 4'h0, 4'h6, 4'hF, 0, 32'h432, 3'd2, 1, 0, 0);
  endtask

  task automatic t_five_byte;
    apply(32'h500, mk(8'h74, 8'h01, 8'h02, 8'h03, 8'h04, 8'h99));
    expect_all("R6 R10 jump", 4'h7, 4'h4, 4'hF, 4'hF, 32'h04030201, 32'h505, 3'd5, 0, 1, 0);
    apply(32'h510, mk(8'h80, 8'hEF, 8'hBE, 8'hAD, 8'hDE, 8'h11));
    expect_all("R6 call", 4'h8, 4'h0, 4'hF, 4'hF, 32'hDEADBEEF, 32'h515, 3'd5, 0, 1, 0);
  endtask

  task automatic t_six_byte;
    apply(32'h600, mk(8'h30, 8'hF2, 8'h78, 8'h56, 8'h34, 8'h12));
    expect_all("R6 movir", 4'h3, 4'h0, 4'hF, 4'h2, 32'h12345678, 32'h606, 3'd6, 1, 1, 0);
    apply(32'h610, mk(8'h40, 8'h15, 8'hEF, 8'hBE, 8'hAD, 8'hDE));
    expect_all("R6 movrm", 4'h4, 4'h0, 4'h1, 4'h5, 32'hDEADBEEF, 32'h616, 3'd6, 1, 1, 0);
    apply(32'h620, mk(8'h50, 8'h73, 8'hFC, 8'hFF, 8'hFF, 8'hFF));
    expect_all("R6 movmr", 4'h5, 4'h0, 4'h7, 4'h3, 32'hFFFFFFFC, 32'h626, 3'd6, 1, 1, 0);
  endtask

  task automatic t_wrap;
    apply(32'hFFFFFFFE, mk(8'h30, 8'hF0, 8'h01, 8'h00, 8'h00, 8'h00));
    expect_all("R8 wrap", 4'h3, 4'h0, 4'hF, 4'h0, 32'h1, 32'h4, 3'd6, 1, 1, 0);
  endtask

  task automatic t_illegal;
    apply(32'h700, mk(8'hC0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A));
    expect_all("R9 icode", 4'hC, 4'h0, 4'hF, 4'hF, 0, 32'h701, 3'd1, 0, 0, 1);
    apply(32'h710, mk(8'h25, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00));
    expect_all("R9 fun", 4'h2, 4'h5, 4'hF, 4'hF, 0, 32'h711, 3'd1, 0, 0, 1);
    apply(32'h720, mk(8'h81, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05));
    expect_all("R9 callfun", 4'h8, 4'h1, 4'hF, 4'hF, 0, 32'h721, 3'd1, 0, 0, 1);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    pc_i = 32'h800;
    bytes_i = mk(8'h61, 8'h45, 8'h00, 8'h00, 8'h00, 8'h00);
    @(negedge clk);
    expect_all("R2 first", 4'h6, 4'h1, 4'h4, 4'h5, 0, 32'h802, 3'd2, 1, 0, 0);
    pc_i = 32'h802;
    bytes_i = mk(8'h70, 8'h10, 8'h20, 8'h30, 8'h40, 8'h00);
    @(negedge clk);
    expect_all("R2 second", 4'h7, 4'h0, 4'hF, 4'hF, 32'h40302010, 32'h807, 3'd5, 0, 1, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_one_byte();
    t_two_byte();
    t_five_byte();
    t_six_byte();
    t_wrap();
    t_illegal();
    t_back_to_back();
    t_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule